// File: doc/BRIEF.md
# Decoupled Prepare-to-Branch Next-PC Unit

This block owns the program counter and decides, once per cycle, where the next instruction comes from. A control transfer is split into three operations that can be scheduled on their own. A *prepare* writes a destination address into one of a small set of target registers. A *compare* writes an equality result into one of a small set of predicate registers. A *branch* names one target register and one predicate register, and it redirects only when that predicate holds. Because the target and the condition are produced ahead of time, they can fill otherwise idle issue slots.

Each cycle the block accepts one bundle of already-decoded fields. The bundle has an optional prepare slot, an optional compare slot, and one flow operation that picks the next PC. Besides the decoupled branch, the flow operation can do a plain sequential step, a PC-relative branch with a short signed displacement, an absolute jump with a long address field, or a jump through a register value, which serves returns and computed targets. Predicate 0 always reads true, so any branch that names it is unconditional. A prepare or compare in the same bundle as a branch that reads the same register is forwarded to that branch.

Top module: `prep_branch_unit`

## Requirements
- R1: While `rstN` is low, `pc` becomes 0, `taken` becomes 0 and predicates 1 to 3 are cleared to false. Target registers are not reset.
- R2: With `flowOp` = 0 (sequential), `pc` advances by 4 on each clock edge and `taken` is 0.
- R3: When `prepValid` is high, target register `prepIdx` takes `prepAddr` on the clock edge.
- R4: When `cmpValid` is high, predicate `cmpIdx` takes (`cmpA` == `cmpB`). Predicate 0 always reads true, and writes to it have no effect.
- R5: With `flowOp` = 1 (branch), if predicate `flowPredIdx` is true then `pc` becomes target register `flowTgtIdx` and `taken` is 1. Otherwise `pc` advances by 4 and `taken` is 0.
- R6: A branch whose target or predicate index matches a prepare or compare in the same bundle uses the newly written value.
- R7: With `flowOp` = 2 (relative), `pc` becomes `pc` plus the 8-bit two's-complement `flowDisp` times 4, and `taken` is 1.
- R8: With `flowOp` = 3 (absolute), `pc` becomes the 24-bit `absField`, zero-extended and shifted left by 2, and `taken` is 1.
- R9: With `flowOp` = 4 (register indirect), `pc` becomes `regVal` unchanged, low bits included, and `taken` is 1.
- R10: The codes 5 to 7 of `flowOp` act as sequential: `pc` advances by 4 and `taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prepValid | input | 1 | Prepare slot is active |
| prepIdx | input | 2 | Target register written by the prepare |
| prepAddr | input | 32 | Destination address to store |
| cmpValid | input | 1 | Compare slot is active |
| cmpIdx | input | 2 | Predicate register written by the compare |
| cmpA | input | 32 | First compare operand |
| cmpB | input | 32 | Second compare operand |
| flowOp | input | 3 | Flow operation: 0 seq, 1 branch, 2 relative, 3 absolute, 4 indirect |
| flowTgtIdx | input | 2 | Target register read by a branch |
| flowPredIdx | input | 2 | Predicate register read by a branch |
| flowDisp | input | 8 | Signed displacement in instruction units |
| absField | input | 24 | Absolute jump address field, in instruction units |
| regVal | input | 32 | Register value for an indirect jump |
| pc | output | 32 | Current program counter |
| taken | output | 1 | The last update was a redirect |

## Verification
The bench targets same-bundle forwarding. A design without it branches to the stale target, or decides on the stale predicate, and lands on the wrong PC. It writes false into predicate 0 and then branches on it, which catches a design that lets predicate 0 be written and so falls through. The relative-branch tests use displacements of -128 and +127 to catch a sign extension or scaling error. Indirect jumps to unaligned values, the widest absolute field, and the undefined flow codes check for a mask, a truncation, or a stray redirect.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  localparam logic [2:0] FLOW_SEQ = 3'd0;
  localparam logic [2:0] FLOW_BR  = 3'd1;
  localparam logic [2:0] FLOW_REL = 3'd2;
  localparam logic [2:0] FLOW_ABS = 3'd3;
  localparam logic [2:0] FLOW_IND = 3'd4;

  // PC source strobes from control to datapath; all clear means sequential.
  typedef struct packed {
    logic useBtr;
    logic useRel;
    logic useAbs;
    logic useInd;
  } pcSel_t;
endpackage

// File: rtl/pbu_ctrl.sv
module pbu_ctrl
  import pbu_pkg::*;
(
  input  logic [2:0] flowOp,
  input  logic       predFwd,
  output pcSel_t     sel
);
  always_comb begin
    sel = '0;
    unique case (flowOp)
      FLOW_BR:  sel.useBtr = predFwd;
      FLOW_REL: sel.useRel = 1'b1;
      FLOW_ABS: sel.useAbs = 1'b1;
      FLOW_IND: sel.useInd = 1'b1;
      default:  sel = '0;
    endcase
  end
endmodule

// File: rtl/pbu_datapath.sv
module pbu_datapath
  import pbu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NT     = 4,
  parameter int NP     = 4,
  parameter int DISP_W = 8,
  parameter int ABS_W  = 24,
  localparam int TW    = $clog2(NT),
  localparam int PW    = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prepValid,
  input  logic [TW-1:0]     prepIdx,
  input  logic [AW-1:0]     prepAddr,
  input  logic              cmpValid,
  input  logic [PW-1:0]     cmpIdx,
  input  logic [AW-1:0]     cmpA,
  input  logic [AW-1:0]     cmpB,
  input  logic [TW-1:0]     flowTgtIdx,
  input  logic [PW-1:0]     flowPredIdx,
  input  logic [DISP_W-1:0] flowDisp,
  input  logic [ABS_W-1:0]  absField,
  input  logic [AW-1:0]     regVal,
  input  pcSel_t            sel,
  output logic              predFwd,
  output logic [AW-1:0]     pc,
  output logic              taken
);
  logic [AW-1:0] btr [NT];
  logic [NP-1:0] pred;
  logic          cmpEq;
  logic [AW-1:0] btrFwd;
  logic [AW-1:0] pcSeq, pcRel, pcAbs, pcNext;

  assign cmpEq = (cmpA == cmpB);

  // Target registers
  for (genvar t = 0; t < NT; t++) begin : g_btr
    always_ff @(posedge clk) begin
      if (prepValid && prepIdx == TW'(t)) btr[t] <= prepAddr;
    end
  end

  // Predicate registers: entry 0 is constant true
  assign pred[0] = 1'b1;
  for (genvar p = 1; p < NP; p++) begin : g_pred
    always_ff @(posedge clk) begin
      if (!rstN)                                pred[p] <= 1'b0;
      else if (cmpValid && cmpIdx == PW'(p))    pred[p] <= cmpEq;
    end
  end

  // Same-bundle forwarding to the branch reader
  always_comb begin
    btrFwd = btr[flowTgtIdx];
    if (prepValid && prepIdx == flowTgtIdx) btrFwd = prepAddr;
    predFwd = pred[flowPredIdx];
    if (flowPredIdx != '0 && cmpValid && cmpIdx == flowPredIdx) predFwd = cmpEq;
  end

  assign pcSeq = pc + AW'(4);
  assign pcRel = pc + {{(AW-DISP_W-2){flowDisp[DISP_W-1]}}, flowDisp, 2'b00};
  assign pcAbs = {{(AW-ABS_W-2){1'b0}}, absField, 2'b00};

  always_comb begin
    pcNext = pcSeq;
    if (sel.useBtr)      pcNext = btrFwd;
    else if (sel.useRel) pcNext = pcRel;
    else if (sel.useAbs) pcNext = pcAbs;
    else if (sel.useInd) pcNext = regVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= '0;
      taken <= 1'b0;
    end else begin
      pc    <= pcNext;
      taken <= |sel;
    end
  end
endmodule

// File: rtl/prep_branch_unit.sv
module prep_branch_unit
  import pbu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NT     = 4,
  parameter int NP     = 4,
  parameter int DISP_W = 8,
  parameter int ABS_W  = 24,
  localparam int TW    = $clog2(NT),
  localparam int PW    = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prepValid,
  input  logic [TW-1:0]     prepIdx,
  input  logic [AW-1:0]     prepAddr,
  input  logic              cmpValid,
  input  logic [PW-1:0]     cmpIdx,
  input  logic [AW-1:0]     cmpA,
  input  logic [AW-1:0]     cmpB,
  input  logic [2:0]        flowOp,
  input  logic [TW-1:0]     flowTgtIdx,
  input  logic [PW-1:0]     flowPredIdx,
  input  logic [DISP_W-1:0] flowDisp,
  input  logic [ABS_W-1:0]  absField,
  input  logic [AW-1:0]     regVal,
  output logic [AW-1:0]     pc,
  output logic              taken
);
  pcSel_t sel;
  logic   predFwd;

  pbu_ctrl u_ctrl (
    .flowOp  (flowOp),
    .predFwd (predFwd),
    .sel     (sel)
  );

  pbu_datapath #(
    .AW(AW), .NT(NT), .NP(NP), .DISP_W(DISP_W), .ABS_W(ABS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .prepValid  (prepValid),
    .prepIdx    (prepIdx),
    .prepAddr   (prepAddr),
    .cmpValid   (cmpValid),
    .cmpIdx     (cmpIdx),
    .cmpA       (cmpA),
    .cmpB       (cmpB),
    .flowTgtIdx (flowTgtIdx),
    .flowPredIdx(flowPredIdx),
    .flowDisp   (flowDisp),
    .absField   (absField),
    .regVal     (regVal),
    .sel        (sel),
    .predFwd    (predFwd),
    .pc         (pc),
    .taken      (taken)
  );
endmodule

// File: rtl/pbu_checker.sv
module pbu_checker
  import pbu_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  flowOp,
  input logic [1:0]  flowPredIdx,
  input logic [7:0]  flowDisp,
  input logic [23:0] absField,
  input logic [31:0] regVal,
  input logic [31:0] pc,
  input logic        taken,
  input pcSel_t      sel
);
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    flowOp == FLOW_SEQ |=> (pc == $past(pc) + 32'd4) && !taken);

  p_pred0_true_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flowOp == FLOW_BR && flowPredIdx == 2'd0) |=> taken);

  p_br_fallthru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flowOp == FLOW_BR && !sel.useBtr) |=> (pc == $past(pc) + 32'd4) && !taken);

  p_rel_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    flowOp == FLOW_REL |=>
      (pc == $past(pc) + {{22{$past(flowDisp[7])}}, $past(flowDisp), 2'b00}) && taken);

  p_abs_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    flowOp == FLOW_ABS |=> (pc == {6'd0, $past(absField), 2'b00}) && taken);

  p_ind_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    flowOp == FLOW_IND |=> (pc == $past(regVal)) && taken);

  p_undef_seq_r10: assert property (@(posedge clk) disable iff (!rstN)
    flowOp > FLOW_IND |=> (pc == $past(pc) + 32'd4) && !taken);

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));
endmodule

bind prep_branch_unit pbu_checker u_chk (.*);

// File: tb/prep_branch_unit_tb.sv
module prep_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        prepValid, cmpValid;
  logic [1:0]  prepIdx, cmpIdx, flowTgtIdx, flowPredIdx;
  logic [31:0] prepAddr, cmpA, cmpB, regVal;
  logic [2:0]  flowOp;
  logic [7:0]  flowDisp;
  logic [23:0] absField;
  logic [31:0] pc;
  logic        taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] btrM [4];
  logic [3:0]  predM;
  logic [31:0] pcM;

  always #2 clk = ~clk;

  prep_branch_unit u_dut (.*);

  function automatic logic [31:0] relTarget(logic [31:0] base, logic [7:0] d);
    return base + {{22{d[7]}}, d, 2'b00};
  endfunction

  function automatic logic [31:0] absTarget(logic [23:0] f);
    return {6'd0, f, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one bundle, update the model, then check after the next edge.
  task automatic doCycle(input bit pv, input logic [1:0] pi, input logic [31:0] pa,
                         input bit cv, input logic [1:0] ci, input logic [31:0] ca,
                         input logic [31:0] cb, input logic [2:0] op,
                         input logic [1:0] ti, input logic [1:0] pri, input logic [7:0] d,
                         input logic [23:0] af, input logic [31:0] rv, input string tag);
    logic [31:0] tgt;
    logic        pr, expTaken;
    logic [31:0] expPc;
    prepValid = pv; prepIdx = pi; prepAddr = pa;
    cmpValid = cv; cmpIdx = ci; cmpA = ca; cmpB = cb;
    flowOp = op; flowTgtIdx = ti; flowPredIdx = pri; flowDisp = d;
    absField = af; regVal = rv;
    tgt = (pv && pi == ti) ? pa : btrM[ti];
    pr  = (pri == 2'd0) ? 1'b1 : ((cv && ci == pri) ? (ca == cb) : predM[pri]);
    expTaken = 1'b1;
    case (op)
      3'd1: begin
        expPc = pr ? tgt : pcM + 32'd4;
        expTaken = pr;
      end
      3'd2: expPc = relTarget(pcM, d);
      3'd3: expPc = absTarget(af);
      3'd4: expPc = rv;
      default: begin
        expPc = pcM + 32'd4;
        expTaken = 1'b0;
      end
    endcase
    if (pv) btrM[pi] = pa;
    if (cv && ci != 2'd0) predM[ci] = (ca == cb);
    pcM = expPc;
    @(negedge clk);
    chk(pc == expPc, {tag, " pc"}, pc, expPc);
    chk(taken == expTaken, {tag, " taken"}, {31'd0, taken}, {31'd0, expTaken});
  endtask

  task automatic seqStep(input string tag);
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0;
    prepValid = 0; prepIdx = 0; prepAddr = 0; cmpValid = 0; cmpIdx = 0;
    cmpA = 0; cmpB = 0; flowOp = 0; flowTgtIdx = 0; flowPredIdx = 0;
    flowDisp = 0; absField = 0; regVal = 0;
    foreach (btrM[i]) btrM[i] = 32'd0;
    predM = 4'b0001;
    pcM = 32'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(pc == 32'd0, "R1 pc after reset", pc, 32'd0);
    chk(taken == 1'b0, "R1 taken after reset", {31'd0, taken}, 32'd0);
    for (int p = 1; p < 4; p++)
      doCycle(0, 0, 0, 0, 0, 0, 0, 3'd1, 2'(p), 2'(p), 0, 0, 0, "R1 predicate cleared");

    // R2: sequential stepping
    for (int i = 0; i < 3; i++) seqStep("R2");

    // R3: load every target register, then branch on pred0 through each
    for (int t = 0; t < 4; t++)
      doCycle(1, 2'(t), 32'h1000 * (t + 1), 0, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0, "R3 prepare");
    for (int t = 0; t < 4; t++)
      doCycle(0, 0, 0, 0, 0, 0, 0, 3'd1, 2'(t), 2'd0, 0, 0, 0, "R3 branch via target");

    // R4: compare true/false, and predicate 0 write has no effect
    doCycle(0, 0, 0, 1, 2'd2, 32'd7, 32'd7, 3'd0, 0, 0, 0, 0, 0, "R4 cmp equal");
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd1, 2'd1, 2'd2, 0, 0, 0, "R4 pred set -> R5 taken");
    doCycle(0, 0, 0, 1, 2'd2, 32'd7, 32'd8, 3'd0, 0, 0, 0, 0, 0, "R4 cmp unequal");
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd1, 2'd1, 2'd2, 0, 0, 0, "R4 pred clear -> R5 fall");
    doCycle(0, 0, 0, 1, 2'd0, 32'd1, 32'd2, 3'd0, 0, 0, 0, 0, 0, "R4 write pred0");
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd1, 2'd3, 2'd0, 0, 0, 0, "R4 pred0 still true");

    // R6: same-bundle forwarding of target and predicate
    doCycle(1, 2'd2, 32'hABC0, 1, 2'd3, 32'd5, 32'd5, 3'd1, 2'd2, 2'd3, 0, 0, 0, "R6 fwd both");
    doCycle(0, 0, 0, 1, 2'd3, 32'd5, 32'd6, 3'd1, 2'd2, 2'd3, 0, 0, 0, "R6 fwd false pred");
    doCycle(1, 2'd1, 32'h7770, 0, 0, 0, 0, 3'd1, 2'd1, 2'd0, 0, 0, 0, "R6 fwd target");

    // R7: displacement extremes
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd2, 0, 0, 8'h80, 0, 0, "R7 disp -128");
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd2, 0, 0, 8'h7F, 0, 0, "R7 disp +127");
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd2, 0, 0, 8'hFF, 0, 0, "R7 disp -1");

    // R8: absolute field extremes
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd3, 0, 0, 0, 24'hFFFFFF, 0, "R8 abs max");
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd3, 0, 0, 0, 24'h000001, 0, "R8 abs small");

    // R9: indirect keeps low bits
    doCycle(0, 0, 0, 0, 0, 0, 0, 3'd4, 0, 0, 0, 0, 32'hDEAD_BEEF, "R9 ind unaligned");

    // R10: undefined codes
    for (int c = 5; c < 8; c++)
      doCycle(0, 0, 0, 0, 0, 0, 0, 3'(c), 0, 0, 8'h10, 24'h55, 32'h1234, "R10 undefined op");

    // Random mix over all requirements
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [2:0] op;
      a = $urandom;
      op = 3'($urandom_range(0, 7));
      doCycle($urandom_range(0, 1), 2'($urandom), {$urandom, 2'b00} ,
              $urandom_range(0, 1), 2'($urandom), a,
              ($urandom_range(0, 1) != 0) ? a : 32'($urandom),
              op, 2'($urandom), 2'($urandom), 8'($urandom), 24'($urandom),
              $urandom, "R2-mix R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule